// File: doc/BRIEF.md
# Two-Requester AXI Write Merge Mux

This block joins the write address (AW), write data (W) and write response (B) channels of two upstream requesters onto a single downstream AXI write port. An arbiter picks which requester's address goes downstream. A small first-word fall-through routing queue records the owner of each issued address, so that write-data beats are always taken from the requester named at the queue head. Responses return to their requester according to one extra high ID bit, which the block adds to the downstream ID.

The routing entry is written when an address first appears valid downstream, not when the downstream side accepts it. A hold flag blocks a second write while that address waits for its ready. The downstream side may therefore accept W beats before, in the same cycle as, or after the matching AW handshake, and no W beat is ever steered without a recorded owner.

Top module: `wr_merge_mux`

## Requirements
- R1: While `rst_ni` is low, `m_aw_valid_o`, `m_w_valid_o` and both bits of `s_w_ready_o` are 0, even when upstream W valid is high.
- R2: Each issued address creates exactly one routing entry, in the first cycle it is valid downstream. A W beat accepted downstream before `m_aw_ready_i` rises consumes that entry, and no second entry appears while the address keeps waiting.
- R3: With no routing entry available, `m_w_valid_o` and both bits of `s_w_ready_o` are 0, whatever the upstream W inputs are.
- R4: W beats are taken only from the requester at the queue head, in the order the addresses were issued. Only that requester's `s_w_ready_o` bit can be 1.
- R5: An entry leaves the queue only on a downstream W handshake whose last flag is 1. Beats without the last flag keep the same owner.
- R6: Once `m_aw_valid_o` is 1 with `m_aw_ready_i` low, the next cycle keeps `m_aw_valid_o` at 1 and keeps the same owner, even if the other requester starts to request.
- R7: When both requesters raise AW in the same cycle, grants alternate. The first grant after reset goes to requester 0.
- R8: When the queue holds DEPTH entries (4 by default), no new address is issued: `m_aw_valid_o` and `s_aw_ready_o` are 0.
- R9: `m_aw_id_o` is the owner index in bit ID_W, above the owner's upstream ID in bits ID_W-1:0.
- R10: A downstream response is routed by `m_b_id_i[ID_W]`: only that requester's `s_b_valid_o` bit follows `m_b_valid_i`, `m_b_ready_o` equals that requester's `s_b_ready_i`, and `s_b_id_o` carries `m_b_id_i[ID_W-1:0]`.
- R11: A W beat can be forwarded downstream in the same cycle its address is first issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_aw_valid_i | input | 2 | Address valid per requester |
| s_aw_ready_o | output | 2 | Address ready per requester |
| s_aw_addr_i | input | 2*ADDR_W | Addresses, requester r at bits r*ADDR_W |
| s_aw_id_i | input | 2*ID_W | Transaction IDs, requester r at bits r*ID_W |
| s_w_valid_i | input | 2 | Data valid per requester |
| s_w_ready_o | output | 2 | Data ready per requester |
| s_w_data_i | input | 2*DATA_W | Write data, requester r at bits r*DATA_W |
| s_w_last_i | input | 2 | Last-beat flag per requester |
| s_b_valid_o | output | 2 | Response valid per requester |
| s_b_ready_i | input | 2 | Response ready per requester |
| s_b_id_o | output | ID_W | Response ID with the owner bit removed |
| s_b_resp_o | output | 2 | Response code |
| m_aw_valid_o | output | 1 | Downstream address valid |
| m_aw_ready_i | input | 1 | Downstream address ready |
| m_aw_addr_o | output | ADDR_W | Downstream address |
| m_aw_id_o | output | ID_W+1 | Downstream ID, owner bit on top |
| m_w_valid_o | output | 1 | Downstream data valid |
| m_w_ready_i | input | 1 | Downstream data ready |
| m_w_data_o | output | DATA_W | Downstream write data |
| m_w_last_o | output | 1 | Downstream last-beat flag |
| m_b_valid_i | input | 1 | Downstream response valid |
| m_b_ready_o | output | 1 | Downstream response ready |
| m_b_id_i | input | ID_W+1 | Downstream response ID |
| m_b_resp_i | input | 2 | Downstream response code |

## Verification
For each requester the bench runs three relative orderings of the two downstream handshakes: W accepted while AW ready is low, both in one cycle, and W after AW. The first ordering separates a design that records ownership at first valid from one that records it at the handshake, because the second would show data again with no owner or lose the route. A queue-filling run with both requesters always requesting, followed by two-beat bursts, separates round-robin order, the full stall and last-beat popping from a wrong owner order. A held-address case and a full sweep of response ID, owner bit and ready show hold stability and response routing.

// File: rtl/wmx_pkg.sv
package wmx_pkg;
    localparam int NREQ = 2;
    typedef logic [NREQ-1:0] req_vec_t;
endpackage

// File: rtl/wmx_route_fifo.sv
module wmx_route_fifo #(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic push_i,
    input  logic owner_i,
    input  logic pop_i,
    output logic full_o,
    output logic avail_o,
    output logic head_o
);
    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [PTR_W:0]   cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     stored_empty;
    logic     bypass;
    logic     do_push;
    logic     do_pop;

    always_comb begin
        st_d         = st_q;
        stored_empty = (st_q.cnt == '0);
        bypass       = stored_empty & push_i & pop_i;
        do_push      = push_i & ~bypass;
        do_pop       = pop_i & ~bypass;
        head_o       = stored_empty ? owner_i : st_q.mem[st_q.rd];
        avail_o      = ~stored_empty | push_i;
        full_o       = (st_q.cnt == (PTR_W+1)'(DEPTH));
        if (do_push) begin
            st_d.mem[st_q.wr] = owner_i;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH-1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH-1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> !full_o);  // R8
    AST_NO_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> avail_o);  // R2
endmodule

// File: rtl/wmx_aw_arb.sv
module wmx_aw_arb
    import wmx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ID_W   = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  req_vec_t               req_i,
    input  logic [2*ADDR_W-1:0]    addr_i,
    input  logic [2*ID_W-1:0]      id_i,
    input  logic                   full_i,
    input  logic                   m_ready_i,
    output logic                   m_valid_o,
    output logic [ADDR_W-1:0]      m_addr_o,
    output logic [ID_W:0]          m_id_o,
    output req_vec_t               s_ready_o,
    output logic                   push_o,
    output logic                   owner_o
);
    typedef struct packed {
        logic lock;
        logic sel;
        logic last;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    pick;

    always_comb begin
        st_d = st_q;
        if (req_i == 2'b11) pick = ~st_q.last;
        else                pick = req_i[1];
        if (st_q.lock) begin
            owner_o   = st_q.sel;
            m_valid_o = 1'b1;
        end else begin
            owner_o   = pick;
            m_valid_o = (|req_i) & ~full_i;
        end
        push_o    = m_valid_o & ~st_q.lock;
        st_d.lock = ~m_ready_i & (m_valid_o | st_q.lock);
        if (push_o) begin
            st_d.sel  = owner_o;
            st_d.last = owner_o;
        end
        m_addr_o  = owner_o ? addr_i[ADDR_W +: ADDR_W] : addr_i[0 +: ADDR_W];
        m_id_o    = {owner_o, owner_o ? id_i[ID_W +: ID_W] : id_i[0 +: ID_W]};
        s_ready_o = '0;
        s_ready_o[owner_o] = m_valid_o & m_ready_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{lock: 1'b0, sel: 1'b0, last: 1'b1};
        else         st_q <= st_d;
    end

    AST_AW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(owner_o)));  // R6
    AST_SINGLE_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_valid_o && !m_ready_i) |=> !push_o);  // R2
    AST_READY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(s_ready_o));  // R6
endmodule

// File: rtl/wmx_w_steer.sv
module wmx_w_steer
    import wmx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                avail_i,
    input  logic                owner_i,
    input  req_vec_t            s_valid_i,
    input  logic [2*DATA_W-1:0] s_data_i,
    input  req_vec_t            s_last_i,
    input  logic                m_ready_i,
    output logic                m_valid_o,
    output logic [DATA_W-1:0]   m_data_o,
    output logic                m_last_o,
    output req_vec_t            s_ready_o,
    output logic                pop_o
);
    always_comb begin
        m_valid_o = avail_i & s_valid_i[owner_i];
        m_data_o  = owner_i ? s_data_i[DATA_W +: DATA_W] : s_data_i[0 +: DATA_W];
        m_last_o  = s_last_i[owner_i];
        s_ready_o = '0;
        s_ready_o[owner_i] = avail_i & m_ready_i;
        pop_o     = m_valid_o & m_ready_i & m_last_o;
    end
endmodule

// File: rtl/wr_merge_mux.sv
module wr_merge_mux
    import wmx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ID_W   = 2,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [1:0]           s_aw_valid_i,
    output logic [1:0]           s_aw_ready_o,
    input  logic [2*ADDR_W-1:0]  s_aw_addr_i,
    input  logic [2*ID_W-1:0]    s_aw_id_i,
    input  logic [1:0]           s_w_valid_i,
    output logic [1:0]           s_w_ready_o,
    input  logic [2*DATA_W-1:0]  s_w_data_i,
    input  logic [1:0]           s_w_last_i,
    output logic [1:0]           s_b_valid_o,
    input  logic [1:0]           s_b_ready_i,
    output logic [ID_W-1:0]      s_b_id_o,
    output logic [1:0]           s_b_resp_o,
    output logic                 m_aw_valid_o,
    input  logic                 m_aw_ready_i,
    output logic [ADDR_W-1:0]    m_aw_addr_o,
    output logic [ID_W:0]        m_aw_id_o,
    output logic                 m_w_valid_o,
    input  logic                 m_w_ready_i,
    output logic [DATA_W-1:0]    m_w_data_o,
    output logic                 m_w_last_o,
    input  logic                 m_b_valid_i,
    output logic                 m_b_ready_o,
    input  logic [ID_W:0]        m_b_id_i,
    input  logic [1:0]           m_b_resp_i
);
    logic push, owner_in, pop, full, avail, head;
    logic b_owner;

    wmx_aw_arb #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_arb (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (s_aw_valid_i),
        .addr_i    (s_aw_addr_i),
        .id_i      (s_aw_id_i),
        .full_i    (full),
        .m_ready_i (m_aw_ready_i),
        .m_valid_o (m_aw_valid_o),
        .m_addr_o  (m_aw_addr_o),
        .m_id_o    (m_aw_id_o),
        .s_ready_o (s_aw_ready_o),
        .push_o    (push),
        .owner_o   (owner_in)
    );

    wmx_route_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (push),
        .owner_i (owner_in),
        .pop_i   (pop),
        .full_o  (full),
        .avail_o (avail),
        .head_o  (head)
    );

    wmx_w_steer #(.DATA_W(DATA_W)) u_steer (
        .avail_i   (avail),
        .owner_i   (head),
        .s_valid_i (s_w_valid_i),
        .s_data_i  (s_w_data_i),
        .s_last_i  (s_w_last_i),
        .m_ready_i (m_w_ready_i),
        .m_valid_o (m_w_valid_o),
        .m_data_o  (m_w_data_o),
        .m_last_o  (m_w_last_o),
        .s_ready_o (s_w_ready_o),
        .pop_o     (pop)
    );

    always_comb begin
        b_owner     = m_b_id_i[ID_W];
        s_b_valid_o = '0;
        s_b_valid_o[b_owner] = m_b_valid_i;
        m_b_ready_o = s_b_ready_i[b_owner];
        s_b_id_o    = m_b_id_i[ID_W-1:0];
        s_b_resp_o  = m_b_resp_i;
    end

    AST_W_NEEDS_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_w_valid_o |-> avail);  // R3
    AST_W_READY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(s_w_ready_o));  // R4
    AST_B_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(s_b_valid_o));  // R10
endmodule

// File: tb/wr_merge_mux_test.sv
module wr_merge_mux_test;
    localparam int ADDR_W = 16;
    localparam int ID_W   = 2;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]          aw_v, aw_rdy, w_v, w_rdy, w_last, b_v, b_rdy;
    logic [2*ADDR_W-1:0] aw_addr;
    logic [2*ID_W-1:0]   aw_id;
    logic [2*DATA_W-1:0] w_data;
    logic [ID_W-1:0]     b_id;
    logic [1:0]          b_resp;
    logic                m_aw_v, m_aw_rdy, m_w_v, m_w_rdy, m_w_last, m_b_v, m_b_rdy;
    logic [ADDR_W-1:0]   m_aw_addr;
    logic [ID_W:0]       m_aw_id, m_b_id;
    logic [DATA_W-1:0]   m_w_data;
    logic [1:0]          m_b_resp;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cnt0, cnt1;

    wr_merge_mux #(.ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W), .DEPTH(4)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .s_aw_valid_i(aw_v), .s_aw_ready_o(aw_rdy), .s_aw_addr_i(aw_addr), .s_aw_id_i(aw_id),
        .s_w_valid_i(w_v), .s_w_ready_o(w_rdy), .s_w_data_i(w_data), .s_w_last_i(w_last),
        .s_b_valid_o(b_v), .s_b_ready_i(b_rdy), .s_b_id_o(b_id), .s_b_resp_o(b_resp),
        .m_aw_valid_o(m_aw_v), .m_aw_ready_i(m_aw_rdy), .m_aw_addr_o(m_aw_addr), .m_aw_id_o(m_aw_id),
        .m_w_valid_o(m_w_v), .m_w_ready_i(m_w_rdy), .m_w_data_o(m_w_data), .m_w_last_o(m_w_last),
        .m_b_valid_i(m_b_v), .m_b_ready_o(m_b_rdy), .m_b_id_i(m_b_id), .m_b_resp_i(m_b_resp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        aw_v = '0; aw_addr = {16'h2000, 16'h1000}; aw_id = {2'd3, 2'd1};
        w_v = '0; w_data = '0; w_last = '0; b_rdy = '0;
        m_aw_rdy = 0; m_w_rdy = 0; m_b_v = 0; m_b_id = '0; m_b_resp = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle_inputs();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic drive_w();
        w_last = {1'(cnt1 % 2), 1'(cnt0 % 2)};
        w_data = {1'b1, 15'(cnt1), 1'b0, 15'(cnt0)};
    endtask

    initial begin
        idle_inputs();
        w_v = 2'b11;
        #5;
        chk("R1 aw valid in reset", 32'(m_aw_v), 0);
        chk("R1 w valid in reset", 32'(m_w_v), 0);
        chk("R1 w ready in reset", 32'(w_rdy), 0);

        // Orderings of W versus AW handshake, per requester
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < 3; k++) begin
                do_reset();
                @(negedge clk);
                aw_v = 2'(1 << r); w_v = 2'(1 << r); w_last = 2'b11;
                w_data = {16'hB000, 16'hA000};
                m_aw_rdy = (k != 0); m_w_rdy = (k != 2);
                #1;
                chk("R2 aw valid issued", 32'(m_aw_v), 1);
                chk("R9 downstream id", 32'(m_aw_id), 32'({1'(r), (r == 1) ? 2'd3 : 2'd1}));
                chk("R11 same-cycle w valid", 32'(m_w_v), 1);
                chk("R11 w ready to owner", 32'(w_rdy), (k != 2) ? 32'(1 << r) : 0);
                chk("R4 w data from owner", 32'(m_w_data), (r == 1) ? 32'hB000 : 32'hA000);
                if (k == 0) begin
                    @(negedge clk); m_aw_rdy = 1; #1;
                    chk("R6 aw still valid", 32'(m_aw_v), 1);
                    chk("R2 no second entry", 32'(m_w_v), 0);
                    chk("R3 w ready gated", 32'(w_rdy), 0);
                    chk("R6 aw ready to owner", 32'(aw_rdy), 32'(1 << r));
                    @(negedge clk); aw_v = 0; #1;
                    chk("R3 idle after both", 32'(m_w_v), 0);
                    chk("R2 aw released", 32'(m_aw_v), 0);
                end else if (k == 1) begin
                    @(negedge clk); aw_v = 0; #1;
                    chk("R3 no entry left", 32'(m_w_v), 0);
                    chk("R2 aw released", 32'(m_aw_v), 0);
                end else begin
                    @(negedge clk); aw_v = 0; m_w_rdy = 1; #1;
                    chk("R2 aw done", 32'(m_aw_v), 0);
                    chk("R5 entry kept until last", 32'(m_w_v), 1);
                    chk("R4 ready to owner", 32'(w_rdy), 32'(1 << r));
                    @(negedge clk); #1;
                    chk("R5 entry popped", 32'(m_w_v), 0);
                end
                w_v = 0;
            end
        end

        // Fill the queue with both requesters contending, then drain bursts
        do_reset();
        @(negedge clk);
        aw_v = 2'b11; m_aw_rdy = 1;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R7 aw issued", 32'(m_aw_v), 1);
            chk("R7 round-robin owner", 32'(m_aw_id[ID_W]), 32'(i % 2));
            @(negedge clk);
        end
        #1;
        chk("R8 stalled when full", 32'(m_aw_v), 0);
        chk("R8 no aw ready when full", 32'(aw_rdy), 0);
        aw_v = 0; w_v = 2'b11; m_w_rdy = 1; cnt0 = 0; cnt1 = 0;
        for (int n = 0; n < 8; n++) begin
            drive_w();
            #1;
            chk("R4 w valid", 32'(m_w_v), 1);
            chk("R4 owner order", 32'(m_w_data[DATA_W-1]), 32'((n / 2) % 2));
            chk("R5 last flag", 32'(m_w_last), 32'(n % 2));
            chk("R4 single ready", 32'(w_rdy), 32'(1 << ((n / 2) % 2)));
            if (w_rdy[0]) cnt0++;
            if (w_rdy[1]) cnt1++;
            @(negedge clk);
        end
        drive_w();
        #1;
        chk("R3 drained", 32'(m_w_v), 0);
        chk("R3 drained ready", 32'(w_rdy), 0);
        w_v = 0; m_w_rdy = 0;

        // Hold while waiting for ready
        do_reset();
        @(negedge clk);
        aw_v = 2'b01; m_aw_rdy = 0; #1;
        chk("R7 first grant", 32'(m_aw_id[ID_W]), 0);
        @(negedge clk); aw_v = 2'b11; #1;
        chk("R6 held valid", 32'(m_aw_v), 1);
        chk("R6 held owner", 32'(m_aw_id[ID_W]), 0);
        chk("R6 held addr", 32'(m_aw_addr), 32'h1000);
        chk("R6 no ready yet", 32'(aw_rdy), 0);
        @(negedge clk); m_aw_rdy = 1; #1;
        chk("R6 accepted owner", 32'(aw_rdy), 1);
        @(negedge clk); aw_v = 2'b10; #1;
        chk("R7 other granted", 32'(m_aw_id[ID_W]), 1);
        chk("R9 other addr", 32'(m_aw_addr), 32'h2000);
        @(negedge clk); aw_v = 0; m_aw_rdy = 0;

        // Response routing sweep
        for (int o = 0; o < 2; o++) begin
            for (int v = 0; v < 4; v++) begin
                for (int rd = 0; rd < 4; rd++) begin
                    @(negedge clk);
                    m_b_v = 1; m_b_id = {1'(o), 2'(v)}; m_b_resp = 2'(v); b_rdy = 2'(rd);
                    #1;
                    chk("R10 b valid", 32'(b_v), 32'(1 << o));
                    chk("R10 b id", 32'(b_id), 32'(v));
                    chk("R10 b ready", 32'(m_b_rdy), 32'((rd >> o) & 1));
                    chk("R10 b resp", 32'(b_resp), 32'(v));
                end
            end
        end
        m_b_v = 0;

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule